// File: doc/BRIEF.md
# ADC Result Window Guard

This block watches the stream of conversion results leaving an ADC. Each result arrives with a valid strobe, its channel number and a bit that says whether it came from the injected sequence or the regular one. Software programs a lower and an upper threshold. When a result that software chose to watch falls outside that window, the block raises a sticky status flag. The flag can also drive an interrupt line.

Software decides which results are watched with three configuration fields. A single-channel select bit and a 5-bit channel index narrow the watch to one channel. Two independent enables turn on watching of regular results and of injected results. Thresholds are compared against the raw 12-bit result, before any alignment shift. The flag stays set until software writes 1 to it.

The register file has four word addresses. Address 0 holds the thresholds, address 1 the configuration, address 2 the status, and address 3 the interrupt enable. A write takes effect at the clock edge where `reg_we` is high. Reads are combinational from `reg_addr`.

Top module: `adc_window_guard`

## Requirements
- R1: After reset, address 0 reads 0x0FFF0000 (lower threshold 0 in bits [11:0], upper threshold 0xFFF in bits [27:16]). Addresses 1, 2 and 3 read 0, `irq` is 0, and with these thresholds no result of any value sets the flag.
- R2: A watched result sets the status flag (address 2 bit 0) on the clock edge where it is presented. It does so only if the raw 12-bit value is strictly below the lower threshold or strictly above the upper threshold. A value equal to either threshold does not set the flag.
- R3: Once set, the flag stays set through later in-range or unwatched results. Writing 1 to address 2 bit 0 clears it. Writing 0 there has no effect.
- R4: If a write-1 clear and a flag-setting result occur on the same edge, the flag ends up set.
- R5: `irq` is 1 exactly when the flag is 1 and the interrupt enable (address 3 bit 0) is 1.
- R6: With the regular enable (address 1 bit 1) and the injected enable (address 1 bit 2) both 0, no result is watched, whatever the single-channel bit (address 1 bit 0) holds.
- R7: With the single-channel bit at 0, every regular result (`res_inj`=0) is watched when the regular enable is 1. Every injected result (`res_inj`=1) is watched when the injected enable is 1. The two enables act independently.
- R8: With the single-channel bit at 1, only results whose `res_chan` equals the channel index (address 1 bits [12:8]) are watched. These are further limited to the regular and/or injected kind by the two enables.
- R9: A result is compared only on an edge where `res_valid` is 1. Out-of-range data with `res_valid` low leaves the flag unchanged.
- R10: Fields written to addresses 0, 1 and 3 read back unchanged at the bit positions given above. Bits outside those fields read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| res_valid | input | 1 | Conversion result valid |
| res_data | input | 12 | Raw conversion result |
| res_chan | input | 5 | Channel number of the result |
| res_inj | input | 1 | 1 = injected result, 0 = regular result |
| irq | output | 1 | Interrupt request |

## Verification
The bench probes values exactly equal to each threshold. A design that used an inclusive comparison would flag them. It also drives a write-1 clear on the same edge as an out-of-range result, where a design that gave the clear priority would lose the event. It sweeps every combination of the single, regular and injected selects, using wrong-channel and wrong-kind results. This catches a guard that ignores the index, merges the two enables, or watches anything while both enables are 0. Finally, it holds out-of-range data with the valid strobe low and writes 0 to the status bit. Either of these changes the flag in a design that compares without the strobe or clears on any write.

// File: rtl/awg_pkg.sv
package awg_pkg;
  // register word addresses
  typedef enum logic [1:0] {
    AWG_A_THRESH = 2'd0,
    AWG_A_CFG    = 2'd1,
    AWG_A_STAT   = 2'd2,
    AWG_A_IEN    = 2'd3
  } awg_addr_e;

  // field positions
  localparam int AWG_LO_LSB     = 0;
  localparam int AWG_HI_LSB     = 16;
  localparam int AWG_SINGLE_BIT = 0;
  localparam int AWG_REGEN_BIT  = 1;
  localparam int AWG_INJEN_BIT  = 2;
  localparam int AWG_IDX_LSB    = 8;
  localparam int AWG_FLAG_BIT   = 0;
  localparam int AWG_IEN_BIT    = 0;
endpackage

// File: rtl/awg_regs.sv
module awg_regs
  import awg_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CHAN_W = 5,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              flag,
  output logic [REG_W-1:0]  rdata,
  output logic [DATA_W-1:0] lo_thr,
  output logic [DATA_W-1:0] hi_thr,
  output logic              sel_single,
  output logic              sel_reg,
  output logic              sel_inj,
  output logic [CHAN_W-1:0] sel_idx,
  output logic              int_en,
  output logic              clr_evt
);
  localparam logic [DATA_W-1:0] HI_RESET = {DATA_W{1'b1}};

  logic wr_thr, wr_cfg, wr_stat, wr_ien;

  assign wr_thr  = we && (addr == ADDR_W'(AWG_A_THRESH));
  assign wr_cfg  = we && (addr == ADDR_W'(AWG_A_CFG));
  assign wr_stat = we && (addr == ADDR_W'(AWG_A_STAT));
  assign wr_ien  = we && (addr == ADDR_W'(AWG_A_IEN));

  // write-1-to-clear request toward the status flag
  assign clr_evt = wr_stat && wdata[AWG_FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_thr     <= '0;
      hi_thr     <= HI_RESET;
      sel_single <= 1'b0;
      sel_reg    <= 1'b0;
      sel_inj    <= 1'b0;
      sel_idx    <= '0;
      int_en     <= 1'b0;
    end else begin
      if (wr_thr) begin
        lo_thr <= wdata[AWG_LO_LSB +: DATA_W];
        hi_thr <= wdata[AWG_HI_LSB +: DATA_W];
      end
      if (wr_cfg) begin
        sel_single <= wdata[AWG_SINGLE_BIT];
        sel_reg    <= wdata[AWG_REGEN_BIT];
        sel_inj    <= wdata[AWG_INJEN_BIT];
        sel_idx    <= wdata[AWG_IDX_LSB +: CHAN_W];
      end
      if (wr_ien) int_en <= wdata[AWG_IEN_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(AWG_A_THRESH): begin
        rdata[AWG_LO_LSB +: DATA_W] = lo_thr;
        rdata[AWG_HI_LSB +: DATA_W] = hi_thr;
      end
      ADDR_W'(AWG_A_CFG): begin
        rdata[AWG_SINGLE_BIT]         = sel_single;
        rdata[AWG_REGEN_BIT]          = sel_reg;
        rdata[AWG_INJEN_BIT]          = sel_inj;
        rdata[AWG_IDX_LSB +: CHAN_W]  = sel_idx;
      end
      ADDR_W'(AWG_A_STAT): rdata[AWG_FLAG_BIT] = flag;
      default:             rdata[AWG_IEN_BIT]  = int_en;
    endcase
  end
endmodule

// File: rtl/awg_guard.sv
module awg_guard #(
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_single,
  input  logic              sel_reg,
  input  logic              sel_inj,
  input  logic [CHAN_W-1:0] sel_idx,
  input  logic [CHAN_W-1:0] chan,
  input  logic              is_inj,
  output logic              guarded
);
  // kind filter, then optional channel filter
  function automatic logic watch(input logic single, input logic ren,
                                 input logic ien, input logic [CHAN_W-1:0] idx,
                                 input logic [CHAN_W-1:0] ch, input logic inj);
    logic kind_ok;
    kind_ok = inj ? ien : ren;
    return kind_ok && (!single || (ch == idx));
  endfunction

  assign guarded = watch(sel_single, sel_reg, sel_inj, sel_idx, chan, is_inj);

  p_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_reg && !sel_inj) |-> !guarded);
  p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_single && guarded) |-> (chan == sel_idx));
endmodule

// File: rtl/awg_window.sv
module awg_window #(
  parameter int DATA_W = 12
) (
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] lo_thr,
  input  logic [DATA_W-1:0] hi_thr,
  output logic              below,
  output logic              above,
  output logic              trip
);
  function automatic logic lt(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return a < b;
  endfunction

  assign below = lt(data, lo_thr);
  assign above = lt(hi_thr, data);
  assign trip  = valid && (below || above);
endmodule

// File: rtl/awg_flag.sv
module awg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  // set has priority over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_evt) flag <= 1'b0;
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
  p_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && clr_evt) |=> flag);
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_evt) |=> flag);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !flag);
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !set_evt) |=> !flag);
endmodule

// File: rtl/adc_window_guard.sv
module adc_window_guard #(
  parameter int DATA_W = 12,
  parameter int CHAN_W = 5,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [CHAN_W-1:0] res_chan,
  input  logic              res_inj,
  output logic              irq
);
  logic [DATA_W-1:0] lo_thr, hi_thr;
  logic              sel_single, sel_reg, sel_inj, int_en;
  logic [CHAN_W-1:0] sel_idx;
  logic              clr_evt, set_evt, guarded, trip, below, above, flag;

  awg_regs #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .flag(flag), .rdata(reg_rdata), .lo_thr(lo_thr), .hi_thr(hi_thr),
    .sel_single(sel_single), .sel_reg(sel_reg), .sel_inj(sel_inj),
    .sel_idx(sel_idx), .int_en(int_en), .clr_evt(clr_evt)
  );

  awg_guard #(.CHAN_W(CHAN_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .sel_single(sel_single), .sel_reg(sel_reg),
    .sel_inj(sel_inj), .sel_idx(sel_idx), .chan(res_chan), .is_inj(res_inj),
    .guarded(guarded)
  );

  awg_window #(.DATA_W(DATA_W)) u_win (
    .valid(res_valid), .data(res_data), .lo_thr(lo_thr), .hi_thr(hi_thr),
    .below(below), .above(above), .trip(trip)
  );

  assign set_evt = trip && guarded;

  awg_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_evt(clr_evt), .flag(flag)
  );

  assign irq = flag && int_en;

  p_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && int_en));
  p_irqen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && int_en) |-> irq);
  p_novalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && !clr_evt) |=> (flag == $past(flag)));
endmodule

// File: tb/adc_window_guard_test.sv
`timescale 1ns/1ps
module adc_window_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        res_valid = 1'b0;
  logic [11:0] res_data = '0;
  logic [4:0]  res_chan = '0;
  logic        res_inj = 1'b0;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench-side model
  logic [11:0] m_lo = 12'h000, m_hi = 12'hFFF;
  bit m_single, m_ren, m_ien, m_flag, m_ie;
  logic [4:0] m_idx;

  bit    q_flag[$];
  bit    q_irq[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  adc_window_guard uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .res_valid(res_valid),
    .res_data(res_data), .res_chan(res_chan), .res_inj(res_inj), .irq(irq)
  );

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit model_watch(input logic [4:0] ch, input bit inj);
    if (!m_ren && !m_ien) return 1'b0;
    if (m_single && ch != m_idx) return 1'b0;
    if (inj) return m_ien;
    return m_ren;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 2'd2 && d[0]) m_flag = 1'b0;
    if (a == 2'd0) begin m_lo = d[11:0]; m_hi = d[27:16]; end
    if (a == 2'd1) begin m_single = d[0]; m_ren = d[1]; m_ien = d[2]; m_idx = d[12:8]; end
    if (a == 2'd3) m_ie = d[0];
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check32(tag, reg_rdata, exp);
  endtask

  // driver: present one result, push its expected outcome
  task automatic conv(input string tag, input logic [11:0] d, input logic [4:0] ch, input bit inj);
    @(negedge clk);
    res_valid = 1'b1; res_data = d; res_chan = ch; res_inj = inj;
    if (model_watch(ch, inj) && (d > m_hi || d < m_lo)) m_flag = 1'b1;
    q_flag.push_back(m_flag);
    q_irq.push_back(m_flag && m_ie);
    q_tag.push_back(tag);
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic clear_flag();
    wr(2'd2, 32'h1);
  endtask

  // monitor: pops expected items as results take effect
  initial begin
    forever begin
      @(posedge clk);
      if (res_valid) begin
        @(negedge clk);
        #0.5;
        if (q_tag.size() != 0) begin
          string t;
          bit ef, ei;
          t = q_tag.pop_front(); ef = q_flag.pop_front(); ei = q_irq.pop_front();
          reg_addr = 2'd2;
          #0.5;
          check32({t, " flag"}, {31'd0, reg_rdata[0]}, {31'd0, ef});
          check32({t, " irq"}, {31'd0, irq}, {31'd0, ei});
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_single = 0; m_ren = 0; m_ien = 0; m_flag = 0; m_ie = 0; m_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd("R1 thresh", 2'd0, 32'h0FFF_0000);
    rd("R1 cfg", 2'd1, 32'h0);
    rd("R1 stat", 2'd2, 32'h0);
    rd("R1 ien", 2'd3, 32'h0);
    check32("R1 irq", {31'd0, irq}, 32'h0);
    wr(2'd1, 32'h0000_0006);
    conv("R1 zero", 12'h000, 5'd3, 1'b0);
    conv("R1 full", 12'hFFF, 5'd3, 1'b1);

    // R10 readback
    wr(2'd0, 32'hFFFF_FFFF);
    rd("R10 thresh", 2'd0, 32'h0FFF_0FFF);
    wr(2'd1, 32'hFFFF_FFFF);
    rd("R10 cfg", 2'd1, 32'h0000_1F07);
    wr(2'd3, 32'hFFFF_FFFF);
    rd("R10 ien", 2'd3, 32'h0000_0001);
    wr(2'd3, 32'h0);

    // R2 boundaries
    wr(2'd0, 32'h0E00_0100);
    wr(2'd1, 32'h0000_0002);
    conv("R2 eq low", 12'h100, 5'd1, 1'b0);
    conv("R2 eq high", 12'hE00, 5'd1, 1'b0);
    conv("R2 below", 12'h0FF, 5'd1, 1'b0);
    clear_flag();
    rd("R3 w1c", 2'd2, 32'h0);
    conv("R2 above", 12'hE01, 5'd9, 1'b0);

    // R3 sticky, R5 irq
    conv("R3 inwin", 12'h500, 5'd1, 1'b0);
    wr(2'd2, 32'h0);
    rd("R3 write0", 2'd2, 32'h1);
    check32("R5 irq off", {31'd0, irq}, 32'h0);
    wr(2'd3, 32'h1);
    check32("R5 irq on", {31'd0, irq}, 32'h1);
    clear_flag();
    check32("R5 irq clr", {31'd0, irq}, 32'h0);

    // R9 valid low
    @(negedge clk);
    res_data = 12'h001; res_chan = 5'd1; res_inj = 1'b0;
    repeat (2) @(negedge clk);
    rd("R9 novalid", 2'd2, 32'h0);
    check32("R9 irq", {31'd0, irq}, 32'h0);

    // R7 independent enables
    conv("R7 inj unwatched", 12'h001, 5'd2, 1'b1);
    conv("R7 reg watched", 12'h001, 5'd2, 1'b0);
    clear_flag();
    wr(2'd1, 32'h0000_0004);
    conv("R7 reg unwatched", 12'hFFF, 5'd2, 1'b0);
    conv("R7 inj watched", 12'hFFF, 5'd2, 1'b1);
    clear_flag();

    // R6 no enables
    wr(2'd1, 32'h0000_0701);
    conv("R6 single none", 12'h000, 5'd7, 1'b0);
    conv("R6 single none inj", 12'h000, 5'd7, 1'b1);
    wr(2'd1, 32'h0);
    conv("R6 all none", 12'hFFF, 5'd0, 1'b1);

    // R8 single channel
    wr(2'd1, 32'h0000_0703);
    conv("R8 other chan", 12'h000, 5'd6, 1'b0);
    conv("R8 wrong kind", 12'h000, 5'd7, 1'b1);
    conv("R8 match reg", 12'h000, 5'd7, 1'b0);
    clear_flag();
    wr(2'd1, 32'h0000_0705);
    conv("R8 reg off", 12'h000, 5'd7, 1'b0);
    conv("R8 match inj", 12'h000, 5'd7, 1'b1);
    clear_flag();
    wr(2'd1, 32'h0000_0707);
    conv("R8 both other", 12'hFFF, 5'd8, 1'b1);
    conv("R8 both inj", 12'hFFF, 5'd7, 1'b1);
    clear_flag();

    // R4 set beats clear
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h1;
    res_valid = 1'b1; res_data = 12'h000; res_chan = 5'd7; res_inj = 1'b0;
    m_flag = 1'b1;
    q_flag.push_back(1'b1); q_irq.push_back(m_ie); q_tag.push_back("R4 set wins");
    @(negedge clk);
    reg_we = 1'b0; res_valid = 1'b0;
    repeat (2) @(negedge clk);
    rd("R4 after", 2'd2, 32'h1);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule